// File: doc/BRIEF.md
# Configurable-Format Asynchronous Serial Receiver

This block takes an asynchronous serial line and turns each character on it into a parallel word. It runs from the core clock. A one-cycle enable, `tick16`, arrives sixteen times per bit period, and only cycles that carry this enable advance the receive logic. A small format register selects the data word length (5 to 8 bits) and the parity mode (odd, even or none). The receiver checks only the first stop bit, so any stop length the sender uses is accepted.

Each finished character is placed in a holding register, right-justified, with the unused upper bits at zero. The output side is a valid/acknowledge stream:

- `data_ready` acts as the valid.
- Pulling `dr_clr_n` low for one cycle is the acknowledge.
- The serial side cannot be stalled, so there is no back-pressure. A character that arrives while the previous one is still unacknowledged overwrites it and raises the overrun flag.

Four status flags report the most recent character: data-ready, overrun, framing and parity. Two output enables force the data word or the flags to zero when they are deasserted.

Top module: `async_char_rx`

## Requirements
- R1: Start-bit validation.
  - A low level seen on a tick while idle is taken as tick 0 of a start bit.
  - If the line is high again at tick 8, no character is produced and the receiver returns to idle.
- R2: Data capture and word length.
  - Each bit is sampled at tick 8 of its own 16-tick period, least significant bit first.
  - The length select value L (2 bits) gives 5+L data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
  - The word appears on `rx_data` right-justified to bit 0, with the bits above the length reading 0.
- R3: Parity check.
  - When `par_off` is 0, one parity bit follows the last data bit.
  - With `par_even`=1 the data bits plus the parity bit must hold an even number of ones; with `par_even`=0 they must hold an odd number.
  - A mismatch sets `parity_err` for that character.
- R4: Parity inhibit. When `par_off` is 1, no parity bit is expected and `parity_err` reads 0.
- R5: Transfer timing.
  - The character moves to the holding register on the tick-8 sample of the first stop bit.
  - On the clock after that edge, `data_ready` rises and `framing_err` and `parity_err` take their new values.
- R6: `framing_err` is 1 exactly when the first stop bit sampled low.
- R7: Overrun.
  - At each transfer, `overrun_err` takes the value `data_ready` had at that moment.
  - So the flag is set when the previous character was never acknowledged and cleared otherwise.
- R8: Acknowledge.
  - `dr_clr_n` low on a clock edge clears `data_ready`.
  - If a new character's `data_ready` rise falls on the same edge, the rise wins.
- R9: Master reset.
  - `rst` high clears `data_ready`, `overrun_err`, `framing_err` and `parity_err`, and returns the receiver to idle.
  - It leaves the holding register unchanged.
- R10: Format register.
  - While `cfg_load` is 1 the register follows `len_sel`, `par_off` and `par_even`.
  - When `cfg_load` falls, the register keeps the last value it loaded.
  - Reset loads 8 data bits with parity off.
- R11: Output enables. `data_oe`=0 forces `rx_data` to 0, and `flag_oe`=0 forces all four flags to 0. Neither enable changes the state underneath.
- R12: Cycles without `tick16` leave the receive timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Master reset, active high, synchronous |
| tick16 | input | 1 | Enable at 16 times the bit rate |
| rx_in | input | 1 | Serial line, idles high |
| len_sel | input | 2 | Word length select, 5+value bits |
| par_off | input | 1 | 1 disables parity |
| par_even | input | 1 | 1 even parity, 0 odd parity |
| cfg_load | input | 1 | Format register load, captured as it falls |
| dr_clr_n | input | 1 | Active-low acknowledge that clears data-ready |
| data_oe | input | 1 | Enable for `rx_data` |
| flag_oe | input | 1 | Enable for the four flags |
| rx_data | output | 8 | Received word, right-justified |
| data_ready | output | 1 | A character is waiting (stream valid) |
| overrun_err | output | 1 | The last transfer found data-ready still high |
| framing_err | output | 1 | The last first-stop-bit sample was low |
| parity_err | output | 1 | The last character failed its parity check |

## Verification
The assertions assume that the format register does not change while a character is in flight. They also assume that two transfers are always at least a full frame apart, which holds for any tick rate because a frame spans more than a hundred ticks. The stimulus changes the format only while the line is idle. It holds every serial bit for exactly sixteen ticks, changing the line between edges, and pauses at least one bit period between frames. The bench's reference model follows the same line-level rules, so a format change made mid-frame would only test behaviour the requirements leave open.

// File: rtl/acr_pkg.sv
package acr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       par_off;
    logic       par_even;
  } rx_fmt_t;

  localparam rx_fmt_t FMT_RESET = '{len_sel: 2'b11, par_off: 1'b1, par_even: 1'b0};

endpackage

// File: rtl/acr_cfg_reg.sv
module acr_cfg_reg
  import acr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  rx_fmt_t fmt_in,
  output rx_fmt_t fmt_q
);

  // Follows the inputs while load is high; the value of the last
  // loading cycle remains once load drops.
  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q <= FMT_RESET;
    end else if (load) begin
      fmt_q <= fmt_in;
    end
  end

endmodule

// File: rtl/acr_frame.sv
module acr_frame
  import acr_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int MID  = 8,
  parameter int WMAX = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            rx,
  input  rx_fmt_t         fmt,
  output logic            xfer,
  output logic [WMAX-1:0] xfer_data,
  output logic            xfer_pe,
  output logic            xfer_fe
);

  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(WMAX + 1);
  localparam int WMIN = WMAX - 3;

  rx_state_e       state;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bidx;
  logic [BW-1:0]   nbits;
  logic [WMAX-1:0] shreg;
  logic            pbit;
  logic            at_mid;
  logic            at_end;
  logic            ones;

  assign nbits  = BW'(WMIN) + BW'(fmt.len_sel);
  assign at_mid = (cnt == CW'(MID));
  assign at_end = (cnt == CW'(OVS - 1));

  // Bits enter at the top, so after nbits shifts the word sits in the
  // upper end; shift down to right-justify with zero fill.
  assign xfer_data = shreg >> (WMAX - int'(nbits));
  assign ones      = (^shreg) ^ pbit;
  assign xfer_pe   = !fmt.par_off && (ones ^ ~fmt.par_even);
  assign xfer_fe   = !rx;
  assign xfer      = !rst && tick && (state == ST_STOP) && at_mid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else if (tick) begin
      if (state == ST_IDLE) begin
        if (!rx) begin
          state <= ST_START;
          cnt   <= CW'(1);
          bidx  <= '0;
          shreg <= '0;
          pbit  <= 1'b0;
        end
      end else begin
        cnt <= at_end ? '0 : cnt + CW'(1);
        case (state)
          ST_START: begin
            if (at_mid && rx) begin
              state <= ST_IDLE;
            end else if (at_end) begin
              state <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (at_mid) begin
              shreg <= {rx, shreg[WMAX-1:1]};
            end
            if (at_end) begin
              if (bidx == nbits - BW'(1)) begin
                bidx  <= '0;
                state <= fmt.par_off ? ST_STOP : ST_PAR;
              end else begin
                bidx <= bidx + BW'(1);
              end
            end
          end
          ST_PAR: begin
            if (at_mid) begin
              pbit <= rx;
            end
            if (at_end) begin
              state <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (at_mid) begin
              state <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/acr_status.sv
module acr_status #(
  parameter int WMAX = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dr_clr_n,
  input  logic            xfer,
  input  logic [WMAX-1:0] xfer_data,
  input  logic            xfer_pe,
  input  logic            xfer_fe,
  output logic [WMAX-1:0] hold,
  output logic            dr,
  output logic            ovr,
  output logic            fe,
  output logic            pe,
  output logic            pend
);

  logic pend_fe;
  logic pend_pe;

  // Holding register is deliberately outside the reset domain.
  always_ff @(posedge clk) begin
    if (xfer) begin
      hold <= xfer_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dr      <= 1'b0;
      ovr     <= 1'b0;
      fe      <= 1'b0;
      pe      <= 1'b0;
      pend    <= 1'b0;
      pend_fe <= 1'b0;
      pend_pe <= 1'b0;
    end else begin
      pend <= xfer;
      if (xfer) begin
        ovr     <= dr;
        pend_fe <= xfer_fe;
        pend_pe <= xfer_pe;
      end
      if (pend) begin
        dr <= 1'b1;
        fe <= pend_fe;
        pe <= pend_pe;
      end else if (!dr_clr_n) begin
        dr <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
  import acr_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int MID  = 8,
  parameter int WMAX = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick16,
  input  logic            rx_in,
  input  logic [1:0]      len_sel,
  input  logic            par_off,
  input  logic            par_even,
  input  logic            cfg_load,
  input  logic            dr_clr_n,
  input  logic            data_oe,
  input  logic            flag_oe,
  output logic [WMAX-1:0] rx_data,
  output logic            data_ready,
  output logic            overrun_err,
  output logic            framing_err,
  output logic            parity_err
);

  rx_fmt_t         fmt_in;
  rx_fmt_t         fmt_q;
  logic            xfer;
  logic [WMAX-1:0] xfer_data;
  logic            xfer_pe;
  logic            xfer_fe;
  logic [WMAX-1:0] hold;
  logic            dr_q;
  logic            ovr_q;
  logic            fe_q;
  logic            pe_q;
  logic            pend_q;
  logic [1:0]      cur_len;
  logic            cur_par_off;

  assign fmt_in      = '{len_sel: len_sel, par_off: par_off, par_even: par_even};
  assign cur_len     = fmt_q.len_sel;
  assign cur_par_off = fmt_q.par_off;

  acr_cfg_reg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .load   (cfg_load),
    .fmt_in (fmt_in),
    .fmt_q  (fmt_q)
  );

  acr_frame #(.OVS(OVS), .MID(MID), .WMAX(WMAX)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick16),
    .rx        (rx_in),
    .fmt       (fmt_q),
    .xfer      (xfer),
    .xfer_data (xfer_data),
    .xfer_pe   (xfer_pe),
    .xfer_fe   (xfer_fe)
  );

  acr_status #(.WMAX(WMAX)) u_status (
    .clk       (clk),
    .rst       (rst),
    .dr_clr_n  (dr_clr_n),
    .xfer      (xfer),
    .xfer_data (xfer_data),
    .xfer_pe   (xfer_pe),
    .xfer_fe   (xfer_fe),
    .hold      (hold),
    .dr        (dr_q),
    .ovr       (ovr_q),
    .fe        (fe_q),
    .pe        (pe_q),
    .pend      (pend_q)
  );

  assign rx_data     = data_oe ? hold : '0;
  assign data_ready  = flag_oe & dr_q;
  assign overrun_err = flag_oe & ovr_q;
  assign framing_err = flag_oe & fe_q;
  assign parity_err  = flag_oe & pe_q;

endmodule

// File: rtl/acr_checks.sv
module acr_checks #(
  parameter int WMAX = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            dr_clr_n,
  input logic            xfer,
  input logic [WMAX-1:0] xfer_data,
  input logic [1:0]      len,
  input logic            par_off,
  input logic            dr,
  input logic            ovr,
  input logic            fe,
  input logic            pe,
  input logic            pend
);

  // R2: nothing above the selected length survives right-justification
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    xfer |-> ((xfer_data >> (WMAX - 3 + int'(len))) == '0));

  // R4: inhibited parity never reports an error
  a_r4_inhibit_quiet: assert property (@(posedge clk) disable iff (rst)
    (xfer && par_off) |=> ##1 !pe);

  // R5: data-ready one clock after the transfer edge
  a_r5_ready_follows: assert property (@(posedge clk) disable iff (rst)
    xfer |=> ##1 dr);

  // R7: overrun mirrors data-ready at the transfer
  a_r7_overrun_src: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (ovr == $past(dr)));

  // R8: acknowledge clears when no new character lands
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (!dr_clr_n && !pend) |=> !dr);

  // R9: reset clears every flag
  a_r9_reset_flags: assert property (@(posedge clk)
    rst |=> (!dr && !ovr && !fe && !pe));

endmodule

bind async_char_rx acr_checks #(.WMAX(WMAX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dr_clr_n  (dr_clr_n),
  .xfer      (xfer),
  .xfer_data (xfer_data),
  .len       (cur_len),
  .par_off   (cur_par_off),
  .dr        (dr_q),
  .ovr       (ovr_q),
  .fe        (fe_q),
  .pe        (pe_q),
  .pend      (pend_q)
);

// File: tb/async_char_rx_tb.sv
`timescale 1ns/1ps
module async_char_rx_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rx_in = 1'b1;
  logic [1:0] len_sel = 2'b11;
  logic       par_off = 1'b1;
  logic       par_even = 1'b0;
  logic       cfg_load = 1'b0;
  logic       dr_clr_n = 1'b1;
  logic       data_oe = 1'b1;
  logic       flag_oe = 1'b1;
  logic [7:0] rx_data;
  logic       data_ready, overrun_err, framing_err, parity_err;

  int checks = 0;
  int fails = 0;
  int tick_div = 1;
  int tdc = 0;
  bit started = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  async_char_rx u_dut (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_in(rx_in),
    .len_sel(len_sel), .par_off(par_off), .par_even(par_even),
    .cfg_load(cfg_load), .dr_clr_n(dr_clr_n), .data_oe(data_oe),
    .flag_oe(flag_oe), .rx_data(rx_data), .data_ready(data_ready),
    .overrun_err(overrun_err), .framing_err(framing_err),
    .parity_err(parity_err)
  );

  // tick generator, changes between edges
  always @(negedge clk) begin
    tick16 <= (tdc == 0);
    tdc = (tdc + 1) % tick_div;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int   m_len = 3;
  bit   m_poff = 1, m_even = 0;
  bit   m_busy = 0;
  int   m_t = 0, m_ones = 0;
  logic [7:0] m_word = 0, m_data = 0;
  bit   m_have = 0;
  bit   m_dr = 0, m_oe = 0, m_fe = 0, m_pe = 0;
  bit   m_pend = 0, m_pfe = 0, m_ppe = 0;

  always @(posedge clk) begin : model
    int n, pos, b;
    bit xf, xfe, xpe, old_dr, old_pend;
    logic [7:0] xd;
    started = 1;
    xf = 0; xfe = 0; xpe = 0; xd = 0;
    n = 5 + m_len;
    if (rst) begin
      m_busy = 0; m_dr = 0; m_oe = 0; m_fe = 0; m_pe = 0; m_pend = 0;
      m_len = 3; m_poff = 1; m_even = 0;
    end else begin
      if (tick16) begin
        if (!m_busy) begin
          if (!rx_in) begin
            m_busy = 1; m_t = 0; m_ones = 0; m_word = 0;
          end
        end else begin
          m_t++;
          pos = m_t % 16;
          b = m_t / 16;
          if (pos == 8) begin
            if (b == 0) begin
              if (rx_in) m_busy = 0;
            end else if (b <= n) begin
              m_word[b-1] = rx_in;
              m_ones += int'(rx_in);
            end else if (!m_poff && b == n + 1) begin
              m_ones += int'(rx_in);
            end else begin
              xf = 1; xd = m_word; xfe = !rx_in;
              xpe = !m_poff && ((m_ones % 2) == (m_even ? 1 : 0));
              m_busy = 0;
            end
          end
        end
      end
      old_dr = m_dr;
      old_pend = m_pend;
      if (old_pend) begin
        m_dr = 1; m_fe = m_pfe; m_pe = m_ppe;
      end else if (!dr_clr_n) begin
        m_dr = 0;
      end
      m_pend = xf;
      if (xf) begin
        m_oe = old_dr; m_data = xd; m_have = 1; m_pfe = xfe; m_ppe = xpe;
      end
      if (cfg_load) begin
        m_len = int'(len_sel); m_poff = par_off; m_even = par_even;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R5", "data_ready", int'(data_ready), int'(flag_oe & m_dr));
      chk("R7", "overrun_err", int'(overrun_err), int'(flag_oe & m_oe));
      chk("R6", "framing_err", int'(framing_err), int'(flag_oe & m_fe));
      chk("R3", "parity_err", int'(parity_err), int'(flag_oe & m_pe));
      if (m_have) chk("R2", "rx_data", int'(rx_data), data_oe ? int'(m_data) : 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_ticks(int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick16);
    end
  endtask

  task automatic set_fmt(int len, bit poff, bit even);
    @(negedge clk);
    len_sel = 2'(len); par_off = poff; par_even = even; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic send(logic [7:0] d, int nb, bit pen, bit pval, bit stop_v);
    @(negedge clk); rx_in = 0;
    wait_ticks(16);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); rx_in = d[i];
      wait_ticks(16);
    end
    if (pen) begin
      @(negedge clk); rx_in = pval;
      wait_ticks(16);
    end
    @(negedge clk); rx_in = stop_v;
    wait_ticks(16);
    @(negedge clk); rx_in = 1;
    wait_ticks(20);
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); dr_clr_n = 0;
    @(negedge clk); dr_clr_n = 1;
  endtask

  function automatic bit par_of(logic [7:0] d, int nb, bit even);
    bit p = 0;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return even ? p : ~p;
  endfunction

  initial begin : watchdog
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk("R9", "reset data_ready", int'(data_ready), 0);
    chk("R9", "reset flags", int'({overrun_err, framing_err, parity_err}), 0);

    // R10 reset format is 8 bits no parity; R2 full width
    send(8'hA5, 8, 0, 0, 1);
    chk("R2", "8-bit word", int'(rx_data), 8'hA5);
    chk("R5", "ready after frame", int'(data_ready), 1);
    ack();
    chk("R8", "ack clears ready", int'(data_ready), 0);

    // R3 5 bits even parity, good then bad
    set_fmt(0, 0, 1);
    send(8'hF3, 5, 1, par_of(8'hF3, 5, 1), 1);
    chk("R2", "5-bit right-justified", int'(rx_data), 8'h13);
    chk("R3", "even parity ok", int'(parity_err), 0);
    ack();
    send(8'h0C, 5, 1, ~par_of(8'h0C, 5, 1), 1);
    chk("R3", "even parity bad", int'(parity_err), 1);
    ack();

    // R3 7 bits odd parity
    set_fmt(2, 0, 0);
    send(8'hDA, 7, 1, par_of(8'hDA, 7, 0), 1);
    chk("R2", "7-bit word", int'(rx_data), 8'h5A);
    chk("R3", "odd parity ok", int'(parity_err), 0);
    ack();
    send(8'h33, 7, 1, ~par_of(8'h33, 7, 0), 1);
    chk("R3", "odd parity bad", int'(parity_err), 1);
    ack();

    // R4 6 bits, parity inhibited
    set_fmt(1, 1, 1);
    send(8'hED, 6, 0, 0, 1);
    chk("R4", "no parity error", int'(parity_err), 0);
    chk("R2", "6-bit word", int'(rx_data), 8'h2D);
    ack();

    // R6 framing
    send(8'h15, 6, 0, 0, 0);
    chk("R6", "low stop bit", int'(framing_err), 1);
    ack();
    send(8'h2A, 6, 0, 0, 1);
    chk("R6", "good stop bit", int'(framing_err), 0);

    // R7 overrun: no acknowledge before next character
    send(8'h07, 6, 0, 0, 1);
    chk("R7", "overrun set", int'(overrun_err), 1);
    ack();
    send(8'h08, 6, 0, 0, 1);
    chk("R7", "overrun cleared", int'(overrun_err), 0);
    ack();

    // R1 false start
    @(negedge clk); rx_in = 0;
    wait_ticks(4);
    @(negedge clk); rx_in = 1;
    wait_ticks(40);
    @(negedge clk);
    chk("R1", "no character", int'(data_ready), 0);
    chk("R1", "holding unchanged", int'(rx_data), 8'h08);

    // R11 output enables
    send(8'h3C, 6, 0, 0, 0);
    data_oe = 0; flag_oe = 0;
    @(negedge clk);
    chk("R11", "data forced low", int'(rx_data), 0);
    chk("R11", "flags forced low", int'({data_ready, framing_err}), 0);
    data_oe = 1; flag_oe = 1;
    @(negedge clk);
    chk("R11", "state kept", int'({data_ready, framing_err}), 3);
    chk("R11", "data kept", int'(rx_data), 8'h3C);
    ack();

    // R12 slower ticks
    tick_div = 3;
    send(8'h19, 6, 0, 0, 1);
    chk("R12", "divided tick word", int'(rx_data), 8'h19);
    ack();
    tick_div = 1;

    // R10 capture on falling load, later input changes ignored
    set_fmt(0, 1, 0);
    @(negedge clk); len_sel = 2'b11; par_off = 0;
    send(8'h1B, 5, 0, 0, 1);
    chk("R10", "5-bit format held", int'(rx_data), 8'h1B);
    chk("R10", "parity stays off", int'(parity_err), 0);

    // R9 master reset keeps holding register
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R9", "flags cleared", int'({data_ready, overrun_err, framing_err, parity_err}), 0);
    chk("R9", "holding kept", int'(rx_data), 8'h1B);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule